// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital front of a multi-channel successive-approximation converter. Software sets it up through one 8-bit control register on a simple register bus. A sequence can be started by writing a start address, or by an event on an external trigger pin. The controller then asks the converter for one channel at a time, from channel 0 up to the last channel. Each result is stored in its own result register, and each channel gets a conversion-complete flag. When the last channel finishes, a sequence flag is raised and, if enabled, an interrupt.

The block also handles power. The power bit drives the converter's power line. After power-up, a programmable recovery count must pass before a conversion may start. A wait-mode input can halt the converter when the wait power-down bit is set. On wake-up the interrupted channel is asked for again, and its result is marked invalid. Any write to the control register abandons a running sequence and does not start a new one. Complete flags clear in one of two ways: by reading the status register and then the result register, or, in fast mode, by any access to the result register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x000, `irq` is 0 and `conv_pwr` is 0.
- R2: Control register at address 0. Bit 7 is power-up, bit 6 fast clear, bit 5 wait power-down, bit 4 trigger mode (0 edge, 1 level), bit 3 trigger polarity (1 rising or high, 0 falling or low), bit 2 trigger enable, bit 1 interrupt enable, and bit 0 the sequence flag. Bits 7..1 read back as written. Writing 1 to bit 0 clears the flag; writing 0 leaves it unchanged. `conv_pwr` is 0 whenever bit 7 is 0.
- R3: A write to address 2 starts a sequence only when the block is idle, powered and recovered. The block then issues exactly one single-cycle `conv_req` per channel, for channels 0..NUM_CH-1 in order. Each result reads at address 16+ch, with data in bits [DATA_W-1:0] and bit 15 as the invalid mark. The status register at address 1 holds the complete flags in bits [NUM_CH-1:0] and the busy bit in bit NUM_CH.
- R4: When the last channel's result is stored, the sequence flag (bit 0) sets. `irq` is high exactly when the flag and the interrupt enable (bit 1) are both set.
- R5: Any write to the control register abandons a running sequence. No further `conv_req` follows, busy clears, the flag does not set, and no new sequence begins.
- R6: With fast clear off, a result read clears that channel's complete flag only if a status read came after the previous result read. A result read without such a status read leaves the flag set.
- R7: With fast clear on, any read or write of a channel's result register clears that channel's complete flag.
- R8: Once `conv_pwr` rises, `conv_req` stays low and start requests are ignored until RECOVER_CYC cycles have passed.
- R9: With bit 5 set and `wait_mode` high, `conv_pwr` is 0 and no `conv_req` is issued. With bit 5 clear, a sequence runs to completion while `wait_mode` is high.
- R10: After a halt caused by wait mode, the interrupted channel is requested again once recovery has passed. That channel's stored result has bit 15 set, and later results do not.
- R11: With the trigger enabled, the synchronised trigger pin starts a sequence. In edge mode it is the edge chosen by the polarity bit; in level mode it is the level chosen by the polarity bit. The opposite edge starts nothing.
- R12: While the trigger is enabled, the result for channel TRIG_CH is stored with bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| wait_mode | input | 1 | Chip wait-mode indication |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_pwr | output | 1 | Converter power enable |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 3 | Channel of the current request |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 10 | Converter result |
| irq | output | 1 | Sequence-complete interrupt |

## Verification
On every cycle the assertions check several rules. No request may appear before recovery has passed or while wait mode powers the converter down. Every request lasts one cycle. A control write is never followed by a request in the next cycle. The interrupt never rises without its enable, and the power line stays low while the power bit is clear. Other behaviours can only be shown by the bench's scenarios, because each depends on a sequence of bus accesses. These are the channel order, the stored data, the two flag-clearing disciplines, the invalid marks after a wake-up and on the trigger channel, and which trigger edges or levels start a sequence.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the ADC sequence controller.
// Assumes the bus address is 5 bits wide and read data is 16 bits wide.
package adc_seq_pkg;
    localparam int ADDR_W     = 5;
    localparam int RDATA_W    = 16;
    localparam int INV_BIT    = 15;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] ADDR_START = 5'd2;

    // Control register bit positions
    localparam int B_PWR   = 7;
    localparam int B_FAST  = 6;
    localparam int B_WAIT  = 5;
    localparam int B_LEVEL = 4;
    localparam int B_POL   = 3;
    localparam int B_TRIG  = 2;
    localparam int B_IE    = 1;
    localparam int B_FLAG  = 0;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_BUSY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_trig_detect.sv
// Synchronises the external trigger pin through two flops and reports an
// edge or level event selected by the mode and polarity inputs.
// Assumes the pin is asynchronous; the event is combinational from flops.
module adc_trig_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic level_mode,
    input  logic pol_high,
    output logic evt
);
    logic s1_q, s2_q, s3_q;

    // Synchroniser chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Pick level or edge, rising/high or falling/low
    always_comb begin
        if (level_mode)
            evt = pol_high ? s2_q : !s2_q;
        else
            evt = pol_high ? (s2_q && !s3_q) : (!s2_q && s3_q);
    end
endmodule

// File: rtl/adc_recovery_timer.sv
// Counts cycles since converter power was applied and reports when the
// analog recovery time has passed. Restarts whenever power is removed.
module adc_recovery_timer #(
    parameter int RECOVER_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic powered,
    output logic done
);
    localparam int REC_W = $clog2(RECOVER_CYC + 1);
    localparam logic [REC_W-1:0] REC_MAX = REC_W'(RECOVER_CYC);

    logic [REC_W-1:0] cnt_q;

    // Saturating up-counter cleared while unpowered
    always_ff @(posedge clk) begin
        if (!rst_n || !powered)
            cnt_q <= '0;
        else if (cnt_q != REC_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = powered && (cnt_q == REC_MAX);
endmodule

// File: rtl/adc_flag_bank.sv
// Result storage and per-channel complete flags with both clearing modes.
// Assumes at most one store and one bus access per cycle; a store wins
// over a clear of the same channel in the same cycle.
module adc_flag_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      store_en,
    input  logic [$clog2(NUM_CH)-1:0] store_ch,
    input  logic [DATA_W-1:0]         store_data,
    input  logic                      store_inv,
    input  logic                      fast_clr,
    input  logic                      stat_rd,
    input  logic                      res_rd,
    input  logic                      res_wr,
    input  logic [$clog2(NUM_CH)-1:0] res_ch,
    output logic [NUM_CH-1:0]         ccf,
    output logic [DATA_W-1:0]         res_data,
    output logic                      res_inv
);
    logic [DATA_W-1:0] res_q [NUM_CH];
    logic [NUM_CH-1:0] inv_q;
    logic [NUM_CH-1:0] ccf_q;
    logic              armed_q;
    logic              clr_hit;

    // A result access that clears its channel's flag under the current mode
    assign clr_hit = fast_clr ? (res_rd || res_wr) : (res_rd && armed_q);

    // Result and invalid-mark storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) res_q[i] <= '0;
            inv_q <= '0;
        end else if (store_en) begin
            res_q[store_ch] <= store_data;
            inv_q[store_ch] <= store_inv;
        end
    end

    // Complete flags: set on store, cleared by a qualifying access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccf_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (store_en && store_ch == i[$clog2(NUM_CH)-1:0])
                    ccf_q[i] <= 1'b1;
                else if (clr_hit && res_ch == i[$clog2(NUM_CH)-1:0])
                    ccf_q[i] <= 1'b0;
            end
        end
    end

    // Status-read arming for the normal two-step clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (stat_rd)
            armed_q <= 1'b1;
        else if (res_rd && !fast_clr)
            armed_q <= 1'b0;
    end

    assign ccf      = ccf_q;
    assign res_data = res_q[res_ch];
    assign res_inv  = inv_q[res_ch];
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC sequence controller: control register, sequence state
// machine, power/wait gating and bus read mux.
// Assumes NUM_CH <= 15 so the status word fits in 16 bits, and that the
// converter answers each request with one conv_done pulse.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DATA_W      = 10,
    parameter int RECOVER_CYC = 16,
    parameter int TRIG_CH     = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [7:0]                bus_wdata,
    output logic [RDATA_W-1:0]        bus_rdata,
    input  logic                      wait_mode,
    input  logic                      ext_trig,
    output logic                      conv_pwr,
    output logic                      conv_req,
    output logic [$clog2(NUM_CH)-1:0] conv_ch,
    input  logic                      conv_done,
    input  logic [DATA_W-1:0]         conv_data,
    output logic                      irq
);
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
    localparam logic [CH_W-1:0] TRIG_IX = CH_W'(TRIG_CH);

    logic [7:0]       ctrl_q;
    seq_state_t       state_q;
    logic [CH_W-1:0]  cur_ch_q;
    logic             resume_inv_q;

    logic ctrl_wr, start_wr, stat_rd, res_hit, res_rd, res_wr;
    logic halted, rec_done, run_ok, trig_evt, start_evt;
    logic store_en, store_inv, seq_done;
    logic [CH_W-1:0]   res_ch;
    logic [NUM_CH-1:0] ccf;
    logic [DATA_W-1:0] res_data;
    logic              res_inv;

    // Bus decode
    assign ctrl_wr  = bus_wr && bus_addr == ADDR_CTRL;
    assign start_wr = bus_wr && bus_addr == ADDR_START;
    assign stat_rd  = bus_rd && bus_addr == ADDR_STAT;
    assign res_hit  = bus_addr[4] && (bus_addr[3:0] < 4'(NUM_CH));
    assign res_rd   = bus_rd && res_hit;
    assign res_wr   = bus_wr && res_hit;
    assign res_ch   = CH_W'(bus_addr[3:0]);

    // Power and run gating
    assign halted   = wait_mode && ctrl_q[B_WAIT];
    assign conv_pwr = ctrl_q[B_PWR] && !halted;
    assign run_ok   = conv_pwr && rec_done;

    assign start_evt = (start_wr || (ctrl_q[B_TRIG] && trig_evt)) && run_ok
                       && !ctrl_wr && state_q == SEQ_IDLE;
    assign conv_req  = state_q == SEQ_REQ && run_ok;
    assign conv_ch   = cur_ch_q;
    assign store_en  = state_q == SEQ_BUSY && conv_done && !halted && !ctrl_wr;
    assign store_inv = resume_inv_q || (ctrl_q[B_TRIG] && cur_ch_q == TRIG_IX);
    assign seq_done  = store_en && cur_ch_q == LAST_CH;
    assign irq       = ctrl_q[B_FLAG] && ctrl_q[B_IE];

    adc_trig_detect u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_trig),
        .level_mode (ctrl_q[B_LEVEL]),
        .pol_high   (ctrl_q[B_POL]),
        .evt        (trig_evt)
    );

    adc_recovery_timer #(.RECOVER_CYC(RECOVER_CYC)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .powered (conv_pwr),
        .done    (rec_done)
    );

    adc_flag_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_en   (store_en),
        .store_ch   (cur_ch_q),
        .store_data (conv_data),
        .store_inv  (store_inv),
        .fast_clr   (ctrl_q[B_FAST]),
        .stat_rd    (stat_rd),
        .res_rd     (res_rd),
        .res_wr     (res_wr),
        .res_ch     (res_ch),
        .ccf        (ccf),
        .res_data   (res_data),
        .res_inv    (res_inv)
    );

    // Control register: plain fields written, flag set on completion, W1C
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q[7:1]    <= bus_wdata[7:1];
            ctrl_q[B_FLAG] <= ctrl_q[B_FLAG] && !bus_wdata[B_FLAG];
        end else if (seq_done) begin
            ctrl_q[B_FLAG] <= 1'b1;
        end
    end

    // Sequence state machine; a control write always returns to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            cur_ch_q <= '0;
        end else if (ctrl_wr) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start_evt) begin
                    state_q  <= SEQ_REQ;
                    cur_ch_q <= '0;
                end
                SEQ_REQ:  if (conv_req) state_q <= SEQ_BUSY;
                SEQ_BUSY: begin
                    if (halted) begin
                        state_q <= SEQ_REQ;
                    end else if (conv_done) begin
                        if (cur_ch_q == LAST_CH) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            cur_ch_q <= cur_ch_q + 1'b1;
                            state_q  <= SEQ_REQ;
                        end
                    end
                end
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Marks the first result after a wait-mode halt as invalid
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr)
            resume_inv_q <= 1'b0;
        else if (halted && state_q != SEQ_IDLE)
            resume_inv_q <= 1'b1;
        else if (store_en)
            resume_inv_q <= 1'b0;
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_CTRL) begin
                bus_rdata[7:0] = ctrl_q;
            end else if (bus_addr == ADDR_STAT) begin
                bus_rdata[NUM_CH-1:0] = ccf;
                bus_rdata[NUM_CH]     = state_q != SEQ_IDLE;
            end else if (res_hit) begin
                bus_rdata[DATA_W-1:0] = res_data;
                bus_rdata[INV_BIT]    = res_inv;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Assertion checker for adc_seq_ctrl, attached with bind below.
// Observes ports plus the control register and recovery status.
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic [7:0] ctrl_q,
    input logic       rec_done,
    input logic       wait_mode,
    input logic       conv_req,
    input logic       conv_pwr,
    input logic       irq
);
    // R8
    req_after_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> rec_done);

    // R9
    halt_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && ctrl_q[5]) |-> (!conv_req && !conv_pwr));

    // R3
    single_cycle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R5
    abort_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !conv_req);

    // R4
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[1]);

    // R2
    pwr_bit_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> !conv_pwr);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_q    (ctrl_q),
    .rec_done  (rec_done),
    .wait_mode (wait_mode),
    .conv_req  (conv_req),
    .conv_pwr  (conv_pwr),
    .irq       (irq)
);

// File: tb/adc_seq_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected channel numbers, a monitor
// pops them on each conversion request; directed reads check the rest.
module adc_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic wait_mode = 1'b0, ext_trig = 1'b0;
    logic conv_pwr, conv_req, conv_done;
    logic [2:0] conv_ch;
    logic [DW-1:0] conv_data;
    logic irq;

    int nvec = 0, nerr = 0, req_cnt = 0;
    bit scb_en = 1'b1;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wait_mode(wait_mode), .ext_trig(ext_trig), .conv_pwr(conv_pwr),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data), .irq(irq)
    );

    function automatic logic [DW-1:0] model(int ch);
        return DW'((ch * 37 + 5) & 10'h3FF);
    endfunction

    // Converter stub: answers a request LAT cycles later, drops work if unpowered
    int stub_cnt = 0;
    int stub_ch = 0;
    always @(posedge clk) begin
        if (!rst_n || !conv_pwr) begin
            stub_cnt  <= 0;
            conv_done <= 1'b0;
            conv_data <= '0;
        end else begin
            conv_done <= 1'b0;
            if (conv_req) begin
                stub_cnt <= LAT;
                stub_ch  <= int'(conv_ch);
            end else if (stub_cnt != 0) begin
                stub_cnt <= stub_cnt - 1;
                if (stub_cnt == 1) begin
                    conv_done <= 1'b1;
                    conv_data <= model(stub_ch);
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares each request's channel with the scoreboard
    always @(negedge clk) begin
        if (rst_n && conv_req) begin
            req_cnt++;
            if (scb_en) begin
                if (exp_q.size() == 0) chk("R3 unexpected request", int'(conv_ch), -1);
                else chk("R3 channel order", int'(conv_ch), exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_chk(string req, logic [4:0] a, int exp);
        logic [15:0] d;
        bus_read(a, d);
        chk(req, int'(d), exp);
    endtask

    task automatic start_seq(bit redo_ch1);
        for (int c = 0; c < NCH; c++) begin
            exp_q.push_back(c);
            if (redo_ch1 && c == 1) exp_q.push_back(c);
        end
        bus_write(5'd2, 8'h00);
    endtask

    task automatic wait_reqs(int n);
        for (int i = 0; i < 2000 && req_cnt < n; i++) @(negedge clk);
        chk("R3 request count reached", req_cnt, n);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        nvec++;
        $display("FAIL R3 watchdog expired act=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_chk("R1 ctrl", 5'd0, 0);
        read_chk("R1 status", 5'd1, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 conv_pwr", int'(conv_pwr), 0);

        // R2 power up; R8 start ignored during recovery
        bus_write(5'd0, 8'h82);
        chk("R2 conv_pwr follows bit7", int'(conv_pwr), 1);
        bus_write(5'd2, 8'h00);
        repeat (6) @(negedge clk);
        chk("R8 no request during recovery", req_cnt, 0);
        repeat (16) @(negedge clk);
        read_chk("R2 readback", 5'd0, 'h82);

        // R3/R4 full sequence
        start_seq(1'b0);
        wait_reqs(8);
        repeat (10) @(negedge clk);
        read_chk("R4 flag set", 5'd0, 'h83);
        chk("R4 irq", int'(irq), 1);
        read_chk("R3 status all complete", 5'd1, 'h0FF);
        for (int c = 0; c < NCH; c++)
            read_chk("R3 result data", 5'(16 + c), int'(model(c)));
        // R6 only ch0 cleared (armed by the status read), others kept
        read_chk("R6 one flag cleared", 5'd1, 'h0FE);
        read_chk("R6 armed read", 5'd18, int'(model(2)));
        read_chk("R6 second clear", 5'd1, 'h0FA);

        // R2/R4 write-one-to-clear
        bus_write(5'd0, 8'h83);
        read_chk("R2 flag cleared", 5'd0, 'h82);
        chk("R4 irq low", int'(irq), 0);

        // R7 fast clear by read and by write
        bus_write(5'd0, 8'hC2);
        read_chk("R7 fast read data", 5'd19, int'(model(3)));
        bus_write(5'd20, 8'h00);
        read_chk("R7 flags cleared", 5'd1, 'h0E2);

        // R5 abort
        b = req_cnt;
        start_seq(1'b0);
        wait_reqs(b + 3);
        bus_write(5'd0, 8'hC2);
        exp_q.delete();
        repeat (20) @(negedge clk);
        chk("R5 no request after abort", req_cnt, b + 3);
        read_chk("R5 idle, two flags set", 5'd1, 'h0E3);
        read_chk("R5 no completion flag", 5'd0, 'hC2);

        // R9 wait mode with power-down off: sequence completes
        bus_write(5'd0, 8'h82);
        wait_mode = 1'b1;
        b = req_cnt;
        start_seq(1'b0);
        wait_reqs(b + 8);
        repeat (10) @(negedge clk);
        chk("R9 powered in wait", int'(conv_pwr), 1);
        read_chk("R9 completed in wait", 5'd0, 'h83);
        wait_mode = 1'b0;
        bus_write(5'd0, 8'h83);

        // R9/R10 wait mode with power-down on, halt during ch1
        bus_write(5'd0, 8'hA2);
        b = req_cnt;
        start_seq(1'b1);
        wait_reqs(b + 2);
        @(negedge clk);
        @(negedge clk);
        wait_mode = 1'b1;
        @(negedge clk);
        chk("R9 power off in wait", int'(conv_pwr), 0);
        repeat (10) @(negedge clk);
        chk("R9 no request while halted", req_cnt, b + 2);
        wait_mode = 1'b0;
        wait_reqs(b + 9);
        repeat (10) @(negedge clk);
        read_chk("R10 resumed result invalid", 5'd17, 'h8000 | int'(model(1)));
        read_chk("R10 next result valid", 5'd18, int'(model(2)));

        // R11/R12 rising-edge trigger
        bus_write(5'd0, 8'h8E);
        b = req_cnt;
        for (int c = 0; c < NCH; c++) exp_q.push_back(c);
        @(negedge clk);
        ext_trig = 1'b1;
        wait_reqs(b + 8);
        repeat (10) @(negedge clk);
        read_chk("R12 trigger channel invalid", 5'd23, 'h8000 | int'(model(7)));
        read_chk("R12 other channel valid", 5'd22, int'(model(6)));
        read_chk("R11 sequence by trigger", 5'd0, 'h8F);
        b = req_cnt;
        ext_trig = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11 falling edge ignored", req_cnt, b);

        // R11 low-level trigger keeps starting sequences
        scb_en = 1'b0;
        bus_write(5'd0, 8'h96);
        b = req_cnt;
        repeat (30) @(negedge clk);
        chk("R11 level trigger starts", int'(req_cnt > b), 1);
        bus_write(5'd0, 8'h80);
        repeat (5) @(negedge clk);
        b = req_cnt;
        repeat (15) @(negedge clk);
        chk("R5 stopped after abort", req_cnt, b);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule